// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block runs the SHA-256 compression function over one 512-bit message block and returns the updated 256-bit chaining value. A caller that has already padded its message presents each block in turn with a valid/ready handshake. With each block it supplies either the chaining value returned for the previous block, or a flag that selects the standard initial hash value for the first block of a message. After the final block, the returned state is the digest.

Message expansion and round processing share one stage. The sixteen input words are loaded into a sixteen-entry circular window. Each round either reads an input word or derives the next schedule word from four live entries of the window, and the new word overwrites the entry it replaces. No 64-word schedule array and no queue between stages are needed. After the last of the 64 rounds, the working variables are added to the incoming chaining value to form the result.

Top module: `sha256_compress`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A block is accepted on a clock edge where in_valid and in_ready are both 1. From the next cycle, in_ready stays 0 until out_valid is issued, and in_valid pulses during that time do not start or alter the computation in progress.
- R3: out_valid is a single-cycle pulse. It is seen in the cycle after the 65th rising edge that follows the accepting edge: one edge per round for 64 rounds, plus one edge for the feed-forward.
- R4: With in_use_iv = 1, the chaining value is the standard initial hash value and in_state is ignored.
- R5: With in_use_iv = 0, in_state is used as the chaining value, so multi-block messages can be chained.
- R6: out_state equals the SHA-256 compression of in_block with the chaining value. Bits 511:480 of in_block hold message word 0, and bits 255:224 of in_state and out_state hold hash word H0. Schedule words 16 to 63 are W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32.
- R7: out_state keeps its value from one out_valid pulse to the next.
- R8: in_ready is 1 in the same cycle as out_valid, so a new block can be accepted on the edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | Engine idle, can take a block |
| in_block | input | 512 | Message block, word 0 in the top bits |
| in_state | input | 256 | Chaining value, H0 in the top bits |
| in_use_iv | input | 1 | 1 selects the standard initial hash value |
| out_valid | output | 1 | One-cycle pulse with a new result |
| out_state | output | 256 | Updated chaining value, H0 in the top bits |

## Verification
The single-block "abc" message is run with random bytes on in_state and in_use_iv set, which tells the initial-value path apart from the in_state path. The two-block 448-bit message chains its second block through in_state, and the result is compared with the published digests, so a wrong constant, rotation or word order shows up there. Random blocks with random chaining values and a random initial-value selection are compared with a bench model that uses a full 64-word schedule. This exercises the circular window's indexing across the whole range of rounds. Blocks are also issued back to back, and in_valid is held high during a busy period, to cover the handshake edges.

// File: rtl/sha_pkg.sv
package sha_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_ROUNDS = 64;
    localparam int WIN_DEPTH  = 16;
    localparam int NUM_HWORDS = 8;
    localparam int RND_W      = $clog2(NUM_ROUNDS);
    localparam int WIN_W      = $clog2(WIN_DEPTH);
    localparam int BLOCK_W    = WORD_W * WIN_DEPTH;
    localparam int STATE_W    = WORD_W * NUM_HWORDS;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a; word_t b; word_t c; word_t d;
        word_t e; word_t f; word_t g; word_t h;
    } work_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctrl_e;

    localparam word_t RC_TAB [NUM_ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    localparam logic [STATE_W-1:0] START_HASH = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t f_choose(word_t x, word_t y, word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_major(word_t x, word_t y, word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t big_s0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_s0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_s1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/sha_ctrl.sv
module sha_ctrl
    import sha_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             load,
    output logic             round_en,
    output logic [RND_W-1:0] round_idx,
    output logic             finish
);

    ctrl_e            st_q;
    logic [RND_W-1:0] cnt_q;

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

    assign in_ready  = (st_q == ST_IDLE);
    assign load      = in_ready && in_valid;
    assign round_en  = (st_q == ST_RUN);
    assign finish    = (st_q == ST_FIN);
    assign round_idx = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_valid) begin
                    st_q  <= ST_RUN;
                    cnt_q <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_RND) st_q <= ST_FIN;
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted block closes the door on the next cycle
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R3: one round per edge, no skipped or repeated index
    a_r3_round_step: assert property (@(posedge clk) disable iff (rst)
        (round_en && cnt_q != LAST_RND) |=> (round_en && cnt_q == $past(cnt_q) + 1'b1));

    // R3: the last round is always followed by the feed-forward cycle
    a_r3_last_then_fin: assert property (@(posedge clk) disable iff (rst)
        (round_en && cnt_q == LAST_RND) |=> finish);

endmodule

// File: rtl/sha_sched.sv
module sha_sched
    import sha_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BLOCK_W-1:0] block,
    input  logic               en,
    input  logic [RND_W-1:0]   idx,
    output word_t              w_cur
);

    word_t            win_q [WIN_DEPTH];
    logic [WIN_W-1:0] slot;
    word_t            w_new;

    assign slot = idx[WIN_W-1:0];

    // Slot arithmetic wraps modulo the window depth on its own.
    assign w_new = sml_s1(win_q[slot - WIN_W'(2)]) + win_q[slot - WIN_W'(7)]
                 + sml_s0(win_q[slot - WIN_W'(15)]) + win_q[slot];

    assign w_cur = (idx < RND_W'(WIN_DEPTH)) ? win_q[slot] : w_new;

    generate
        for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    win_q[i] <= '0;
                else if (load)
                    win_q[i] <= block[BLOCK_W-1-i*WORD_W -: WORD_W];
                else if (en && slot == WIN_W'(i))
                    win_q[i] <= w_cur;
            end
        end
    endgenerate

    // R6: input words pass through unchanged during the first rounds
    a_r6_raw_words: assert property (@(posedge clk) disable iff (rst)
        (en && idx < RND_W'(WIN_DEPTH)) |=> (win_q[$past(slot)] == $past(w_cur)));

endmodule

// File: rtl/sha_round.sv
module sha_round
    import sha_pkg::*;
(
    input  work_t cur,
    input  word_t w,
    input  word_t k,
    output work_t nxt
);

    word_t t1, t2;

    always_comb begin
        t1 = cur.h + big_s1(cur.e) + f_choose(cur.e, cur.f, cur.g) + k + w;
        t2 = big_s0(cur.a) + f_major(cur.a, cur.b, cur.c);
        nxt.a = t1 + t2;
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t1;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end

endmodule

// File: rtl/sha256_compress.sv
module sha256_compress
    import sha_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [511:0] in_block,
    input  logic [255:0] in_state,
    input  logic         in_use_iv,
    output logic         out_valid,
    output logic [255:0] out_state
);

    logic             load, round_en, finish;
    logic [RND_W-1:0] round_idx;
    word_t            w_cur;
    work_t            work_q, chain_q, work_nxt, sum;
    logic             ov_q;
    logic [255:0]     os_q;

    sha_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (load),
        .round_en  (round_en),
        .round_idx (round_idx),
        .finish    (finish)
    );

    sha_sched u_sched (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .block (in_block),
        .en    (round_en),
        .idx   (round_idx),
        .w_cur (w_cur)
    );

    sha_round u_round (
        .cur (work_q),
        .w   (w_cur),
        .k   (RC_TAB[round_idx]),
        .nxt (work_nxt)
    );

    always_comb begin
        sum.a = work_q.a + chain_q.a;
        sum.b = work_q.b + chain_q.b;
        sum.c = work_q.c + chain_q.c;
        sum.d = work_q.d + chain_q.d;
        sum.e = work_q.e + chain_q.e;
        sum.f = work_q.f + chain_q.f;
        sum.g = work_q.g + chain_q.g;
        sum.h = work_q.h + chain_q.h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            chain_q <= '0;
            ov_q    <= 1'b0;
            os_q    <= '0;
        end else begin
            ov_q <= finish;
            if (load) begin
                work_q  <= in_use_iv ? work_t'(START_HASH) : work_t'(in_state);
                chain_q <= in_use_iv ? work_t'(START_HASH) : work_t'(in_state);
            end else if (round_en) begin
                work_q <= work_nxt;
            end
            if (finish) os_q <= sum;
        end
    end

    assign out_valid = ov_q;
    assign out_state = os_q;

    // R3: the result strobe never lasts more than a cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: the result only moves together with a strobe
    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (out_valid || $stable(out_state)));

    // R8: the engine is open for the next block while the strobe is high
    a_r8_ready_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R2: chaining value is frozen while a block is in flight
    a_r2_chain_frozen: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(chain_q));

endmodule

// File: tb/sha256_compress_tb.sv
module sha256_compress_tb;
    import sha_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [511:0] in_block;
    logic [255:0] in_state;
    logic         in_use_iv;
    logic         out_valid;
    logic [255:0] out_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha256_compress u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_block  (in_block),
        .in_state  (in_state),
        .in_use_iv (in_use_iv),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_compress(logic [511:0] blk, logic [255:0] h);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        logic [255:0] r;
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
        for (int i = 0; i < 8; i++) v[i] = h[255 - 32*i -: 32];
        for (int i = 0; i < 64; i++) begin
            t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + RC_TAB[i] + w[i];
            t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = v[i] + h[255 - 32*i -: 32];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns at the falling edge where out_valid is seen.
    task automatic run_block(input logic [511:0] blk, input logic [255:0] st,
                             input bit use_iv, input bit hold_valid,
                             output logic [255:0] res);
        int lat;
        check(in_ready === 1'b1, "R8 ready before issue", 256'(in_ready), 256'd1);
        in_valid  = 1'b1;
        in_block  = blk;
        in_state  = st;
        in_use_iv = use_iv;
        @(posedge clk);
        #1;
        if (!hold_valid) in_valid = 1'b0;
        in_block = ~blk;
        in_state = ~st;
        in_use_iv = ~use_iv;
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 60) in_valid = 1'b0;
            if (out_valid === 1'b1) break;
            if (in_ready !== 1'b0) check(1'b0, "R2 ready while busy", 256'(in_ready), 256'd0);
            if (lat > 80) break;
        end
        check(lat == 65, "R3 latency", 256'(lat), 256'd65);
        check(in_ready === 1'b1, "R8 ready with valid", 256'(in_ready), 256'd1);
        res = out_state;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [511:0] blk, b1, b2;
        logic [255:0] st, res, res2, exp;
        bit iv;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_block = '0; in_state = '0; in_use_iv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check(in_ready === 1'b1, "R1 ready after reset", 256'(in_ready), 256'd1);
        check(out_valid === 1'b0, "R1 valid after reset", 256'(out_valid), 256'd0);

        // R4/R6: "abc" with random garbage on in_state, initial value selected
        blk = {"abc", 8'h80, 416'h0, 64'd24};
        st  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        run_block(blk, st, 1'b1, 1'b0, res);
        exp = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
        check(res === exp, "R4 R6 abc digest", res, exp);

        // R3: strobe lasts one cycle; R7: output holds afterwards
        @(negedge clk);
        check(out_valid === 1'b0, "R3 single pulse", 256'(out_valid), 256'd0);
        repeat (5) @(negedge clk);
        check(out_state === exp, "R7 output held", out_state, exp);

        // R5/R6: two-block message chained through in_state, second issued back to back (R8)
        b1 = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'h0};
        b2 = {448'h0, 64'd448};
        run_block(b1, 256'h0, 1'b1, 1'b0, res);
        check(res === ref_compress(b1, START_HASH), "R6 first block", res, ref_compress(b1, START_HASH));
        run_block(b2, res, 1'b0, 1'b0, res2);
        exp = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
        check(res2 === exp, "R5 two-block digest", res2, exp);

        // R2: in_valid held high with other data while busy does not disturb the result
        @(negedge clk);
        blk = {16{$urandom}};
        st  = {8{$urandom}};
        run_block(blk, st, 1'b0, 1'b1, res);
        exp = ref_compress(blk, st);
        check(res === exp, "R2 busy valid ignored", res, exp);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R2 no extra block started",
              {254'h0, out_valid, in_ready}, 256'd1);

        // R6/R5/R4: random blocks and chaining values
        for (int n = 0; n < 12; n++) begin
            for (int i = 0; i < 16; i++) blk[511 - 32*i -: 32] = $urandom;
            for (int i = 0; i < 8; i++) st[255 - 32*i -: 32] = $urandom;
            iv = $urandom % 2;
            run_block(blk, st, iv, 1'b0, res);
            exp = ref_compress(blk, iv ? START_HASH : st);
            check(res === exp, "R6 random block", res, exp);
            if (n % 3 == 0) @(negedge clk);
        end

        // R6: all-ones and all-zero corner blocks
        run_block({512{1'b1}}, {256{1'b1}}, 1'b0, 1'b0, res);
        check(res === ref_compress({512{1'b1}}, {256{1'b1}}), "R6 all ones", res,
              ref_compress({512{1'b1}}, {256{1'b1}}));
        run_block('0, '0, 1'b0, 1'b0, res);
        check(res === ref_compress('0, '0), "R6 all zero", res, ref_compress('0, '0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule